// File: doc/BRIEF.md
# ADC Trigger Sequencer

This block drives one sample-and-hold converter on behalf of a motor current loop. Up to eight slots are configured, and each slot names one event source and one analog input channel. The event sources are two PWM phase events, the ends of six dead-time intervals and a network sync pulse. When a slot's event fires, the slot is queued. The block then starts a conversion on that slot's channel over a start/busy/done handshake with the converter. It sends the 12-bit result out on a write port, at an address equal to a base address plus the slot number. After every enabled slot has delivered its result, it raises a single interrupt. A PWM reload strobe opens the next half cycle.

Each enabled slot converts at most once between two reload strobes. When several slots are waiting, the lowest-numbered slot is served first. An event that hits a slot that is still queued is lost, and the block records this in a sticky overrun flag. The result port uses a valid/ready handshake. While `res_valid` is high and `res_ready` is low, the address and data hold steady. No further conversion starts until the consumer accepts the word. Only one result is ever outstanding, so back-pressure stalls the converter rather than dropping data.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset `adc_start`, `res_valid`, `seq_irq` and `overrun` are all low.
- R2: Source code 0 selects `pwm_phase_evt[0]` and code 1 selects `pwm_phase_evt[1]`. Codes 2 to 7 select `deadtime_end[0]` to `deadtime_end[5]`, and code 8 selects `net_sync`. Codes 9 to 15 never fire.
- R3: An enabled slot whose selected event is high on a clock edge gets exactly one conversion on its channel. Any further events for that slot are ignored until the next reload.
- R4: A slot whose enable bit is low never converts.
- R5: When several slots are queued, they are converted in ascending slot order.
- R6: An event for an enabled slot that is still queued sets `overrun`, and `overrun` stays high until the next reload.
- R7: Each result is written with `res_addr = buf_base + slot` and `res_data` equal to the converter's result, which is 12 bits.
- R8: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_addr` and `res_data` hold. No new `adc_start` occurs until the word is accepted.
- R9: `seq_irq` is a one-cycle pulse. It fires once per half cycle, in the cycle after the result of the last enabled slot is accepted, and never once per conversion.
- R10: `pwm_reload` clears the queue, the once-per-half-cycle record and `overrun`. Events on the same edge as a reload are ignored.
- R11: A conversion in progress when a reload arrives still has its result written. That write does not count toward the interrupt of the new half cycle.
- R12: `adc_start` is a one-cycle pulse, issued only after a cycle in which `adc_busy` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | NUM_SLOTS | Per-slot enable |
| slot_src | input | NUM_SLOTS*4 | Per-slot source code, slot k at bits [4k+3:4k] |
| slot_chan | input | NUM_SLOTS*5 | Per-slot channel, slot k at bits [5k+4:5k] |
| buf_base | input | ADDR_W | Base address of the result buffer |
| pwm_reload | input | 1 | Half-cycle reload strobe |
| pwm_phase_evt | input | 2 | PWM phase event pulses |
| deadtime_end | input | 6 | Dead-time end pulses |
| net_sync | input | 1 | Network sync pulse |
| adc_start | output | 1 | Conversion start pulse |
| adc_chan | output | 5 | Channel for the current conversion |
| adc_busy | input | 1 | Converter busy |
| adc_done | input | 1 | Converter result valid pulse |
| adc_result | input | 12 | Converter result |
| res_valid | output | 1 | Result word valid |
| res_ready | input | 1 | Consumer accepts the word |
| res_addr | output | ADDR_W | Result buffer address |
| res_data | output | 12 | Result word |
| seq_irq | output | 1 | Sequence-complete interrupt pulse |
| overrun | output | 1 | Sticky lost-event flag |

## Verification
Faults in the queue mask show up at the write port as missing, duplicated or reordered addresses, within one conversion time of the event. A faulty once-per-half-cycle record or write count shows up as a second result after a repeated event, or as an interrupt that is missing or comes early relative to the last write. These errors appear within the half cycle in which they occur. A handshake fault shows up as data changing while the port is stalled, or as a converter start during a stall, within a few cycles of the stall.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SRC_W    = 4;
  localparam int NUM_PH   = 2;
  localparam int NUM_DT   = 6;
  localparam int CODE_PH0 = 0;
  localparam int CODE_DT0 = CODE_PH0 + NUM_PH;
  localparam int CODE_NET = CODE_DT0 + NUM_DT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2,
    ST_WRITE = 2'd3
  } conv_state_e;
endpackage

// File: rtl/adc_seq_trig_decode.sv
module adc_seq_trig_decode
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic [NUM_SLOTS*SRC_W-1:0] slot_src,
  input  logic [NUM_PH-1:0]          phase_evt,
  input  logic [NUM_DT-1:0]          dt_evt,
  input  logic                       net_evt,
  output logic [NUM_SLOTS-1:0]       slot_hit
);
  localparam int NUM_CODES = 1 << SRC_W;

  logic [NUM_CODES-1:0] evt_vec;

  always_comb begin
    evt_vec = '0;
    evt_vec[CODE_PH0 +: NUM_PH] = phase_evt;
    evt_vec[CODE_DT0 +: NUM_DT] = dt_evt;
    evt_vec[CODE_NET]           = net_evt;
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slot_hit[g] = evt_vec[slot_src[g*SRC_W +: SRC_W]];
  end
endmodule

// File: rtl/adc_seq_slot_track.sv
module adc_seq_slot_track #(
  parameter int NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reload,
  input  logic [NUM_SLOTS-1:0] slot_en,
  input  logic [NUM_SLOTS-1:0] slot_hit,
  input  logic [NUM_SLOTS-1:0] grant_vec,
  output logic [NUM_SLOTS-1:0] pending,
  output logic                 overrun
);
  logic [NUM_SLOTS-1:0] pending_q, taken_q, accept;
  logic                 overrun_q, ovr_hit;

  assign accept  = slot_hit & slot_en & ~taken_q;
  assign ovr_hit = |(slot_hit & slot_en & pending_q);

  always_ff @(posedge clk) begin
    if (!rst_n || reload) begin
      pending_q <= '0;
      taken_q   <= '0;
      overrun_q <= 1'b0;
    end else begin
      taken_q   <= taken_q | accept;
      pending_q <= (pending_q & ~grant_vec) | accept;
      if (ovr_hit) overrun_q <= 1'b1;
    end
  end

  assign pending = pending_q;
  assign overrun = overrun_q;

  // R6: overrun only rises after a cycle where something was queued
  a_r6_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_q) |-> $past(pending_q != '0));

  // R3: a queued slot has always been recorded as taken this half cycle
  a_r3_pending_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q & ~taken_q) == '0);

  // R10: reload empties the queue and the flag
  a_r10_reload_clears: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (pending_q == '0) && !overrun_q);
endmodule

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] req,
  output logic [NUM_SLOTS-1:0] gnt_vec,
  output logic [IDX_W-1:0]     gnt_idx,
  output logic                 any
);
  always_comb begin
    gnt_vec = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (req[i] && !any) begin
        any        = 1'b1;
        gnt_vec[i] = 1'b1;
        gnt_idx    = IDX_W'(i);
      end
    end
  end

  // R5: at most one slot chosen, and only a requesting one
  always_comb begin
    a_r5_one_pick: assert ($onehot0(gnt_vec) && ((gnt_vec & ~req) == '0));
  end
endmodule

// File: rtl/adc_seq_conv_fsm.sv
module adc_seq_conv_fsm
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int CH_W      = 5,
  parameter int RES_W     = 12,
  parameter int ADDR_W    = 8,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reload,
  input  logic                      any_pend,
  input  logic [IDX_W-1:0]          pick_idx,
  input  logic [NUM_SLOTS-1:0]      pick_vec,
  input  logic [NUM_SLOTS*CH_W-1:0] slot_chan,
  input  logic [NUM_SLOTS-1:0]      slot_en,
  input  logic [ADDR_W-1:0]         buf_base,
  input  logic                      adc_busy,
  input  logic                      adc_done,
  input  logic [RES_W-1:0]          adc_result,
  input  logic                      wr_ready,
  output logic [NUM_SLOTS-1:0]      grant_vec,
  output logic                      adc_start,
  output logic [CH_W-1:0]           adc_chan,
  output logic                      wr_valid,
  output logic [ADDR_W-1:0]         wr_addr,
  output logic [RES_W-1:0]          wr_data,
  output logic                      irq
);
  conv_state_e          state_q, state_d;
  logic [IDX_W-1:0]     slot_q;
  logic [CH_W-1:0]      chan_q, chan_sel;
  logic [RES_W-1:0]     data_q;
  logic [NUM_SLOTS-1:0] wrote_q, slot_bit;
  logic                 stale_q, irq_q, grant, wr_fire, counts;

  assign grant     = (state_q == ST_IDLE) && any_pend && !adc_busy && !reload;
  assign grant_vec = grant ? pick_vec : '0;
  assign chan_sel  = slot_chan[int'(pick_idx)*CH_W +: CH_W];
  assign wr_fire   = (state_q == ST_WRITE) && wr_ready;
  assign slot_bit  = NUM_SLOTS'(1) << slot_q;
  assign counts    = wr_fire && !stale_q && !reload;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (grant)    state_d = ST_START;
      ST_START:               state_d = ST_WAIT;
      ST_WAIT:  if (adc_done) state_d = ST_WRITE;
      ST_WRITE: if (wr_ready) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      chan_q  <= '0;
      data_q  <= '0;
      wrote_q <= '0;
      stale_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (grant) begin
        slot_q <= pick_idx;
        chan_q <= chan_sel;
      end
      if (state_q == ST_WAIT && adc_done) data_q <= adc_result;
      if (wr_fire)                                stale_q <= 1'b0;
      else if (reload && state_q != ST_IDLE)      stale_q <= 1'b1;
      if (reload)      wrote_q <= '0;
      else if (counts) wrote_q <= wrote_q | slot_bit;
      irq_q <= counts && (((wrote_q | slot_bit) & slot_en) == slot_en);
    end
  end

  assign adc_start = (state_q == ST_START);
  assign adc_chan  = chan_q;
  assign wr_valid  = (state_q == ST_WRITE);
  assign wr_addr   = buf_base + ADDR_W'(slot_q);
  assign wr_data   = data_q;
  assign irq       = irq_q;

  // R12: start is a single-cycle pulse after an idle converter
  a_r12_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  a_r12_start_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> $past(!adc_busy));

  // R8: a stalled word holds its contents
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R9: interrupt is one cycle wide and follows an accepted word
  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r9_irq_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(wr_valid && wr_ready));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int CH_W      = 5,
  parameter int RES_W     = 12,
  parameter int ADDR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SLOTS-1:0]       slot_en,
  input  logic [NUM_SLOTS*SRC_W-1:0] slot_src,
  input  logic [NUM_SLOTS*CH_W-1:0]  slot_chan,
  input  logic [ADDR_W-1:0]          buf_base,
  input  logic                       pwm_reload,
  input  logic [NUM_PH-1:0]          pwm_phase_evt,
  input  logic [NUM_DT-1:0]          deadtime_end,
  input  logic                       net_sync,
  output logic                       adc_start,
  output logic [CH_W-1:0]            adc_chan,
  input  logic                       adc_busy,
  input  logic                       adc_done,
  input  logic [RES_W-1:0]           adc_result,
  output logic                       res_valid,
  input  logic                       res_ready,
  output logic [ADDR_W-1:0]          res_addr,
  output logic [RES_W-1:0]           res_data,
  output logic                       seq_irq,
  output logic                       overrun
);
  localparam int IDX_W = $clog2(NUM_SLOTS);

  logic [NUM_SLOTS-1:0] slot_hit, pending, pick_vec, grant_vec;
  logic [IDX_W-1:0]     pick_idx;
  logic                 any_pend;

  adc_seq_trig_decode #(.NUM_SLOTS(NUM_SLOTS)) u_decode (
    .slot_src  (slot_src),
    .phase_evt (pwm_phase_evt),
    .dt_evt    (deadtime_end),
    .net_evt   (net_sync),
    .slot_hit  (slot_hit)
  );

  adc_seq_slot_track #(.NUM_SLOTS(NUM_SLOTS)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .reload    (pwm_reload),
    .slot_en   (slot_en),
    .slot_hit  (slot_hit),
    .grant_vec (grant_vec),
    .pending   (pending),
    .overrun   (overrun)
  );

  adc_seq_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .req     (pending),
    .gnt_vec (pick_vec),
    .gnt_idx (pick_idx),
    .any     (any_pend)
  );

  adc_seq_conv_fsm #(
    .NUM_SLOTS (NUM_SLOTS),
    .CH_W      (CH_W),
    .RES_W     (RES_W),
    .ADDR_W    (ADDR_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload     (pwm_reload),
    .any_pend   (any_pend),
    .pick_idx   (pick_idx),
    .pick_vec   (pick_vec),
    .slot_chan  (slot_chan),
    .slot_en    (slot_en),
    .buf_base   (buf_base),
    .adc_busy   (adc_busy),
    .adc_done   (adc_done),
    .adc_result (adc_result),
    .wr_ready   (res_ready),
    .grant_vec  (grant_vec),
    .adc_start  (adc_start),
    .adc_chan   (adc_chan),
    .wr_valid   (res_valid),
    .wr_addr    (res_addr),
    .wr_data    (res_data),
    .irq        (seq_irq)
  );

  // R1: quiet outputs in the first cycle out of reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> !adc_start && !res_valid && !seq_irq && !overrun);
endmodule

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;
  localparam int NS = 8;
  localparam logic [7:0] BASE = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NS-1:0]   slot_en = '0;
  logic [NS*4-1:0] slot_src = '0;
  logic [NS*5-1:0] slot_chan = '0;
  logic        pwm_reload = 1'b0;
  logic [1:0]  phase = '0;
  logic [5:0]  dt = '0;
  logic        net = 1'b0;
  logic        adc_start, adc_busy, adc_done;
  logic [4:0]  adc_chan;
  logic [11:0] adc_result;
  logic        res_valid, res_ready;
  logic [7:0]  res_addr;
  logic [11:0] res_data;
  logic        seq_irq, overrun;

  logic        mdl_busy = 1'b0, ext_busy = 1'b0;
  logic [4:0]  mdl_ch = '0;
  int          mdl_cnt = 0, adc_lat = 4;

  int checks = 0, fails = 0;
  int n_wr = 0, irq_cnt = 0, start_cnt = 0, n_at_irq = -1;
  logic [7:0]  log_addr [0:31];
  logic [11:0] log_data [0:31];

  always #10 clk = ~clk;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .slot_src(slot_src),
    .slot_chan(slot_chan), .buf_base(BASE), .pwm_reload(pwm_reload),
    .pwm_phase_evt(phase), .deadtime_end(dt), .net_sync(net),
    .adc_start(adc_start), .adc_chan(adc_chan), .adc_busy(adc_busy),
    .adc_done(adc_done), .adc_result(adc_result), .res_valid(res_valid),
    .res_ready(res_ready), .res_addr(res_addr), .res_data(res_data),
    .seq_irq(seq_irq), .overrun(overrun)
  );

  // converter model: result = {channel, 7'h2A}
  assign adc_busy   = mdl_busy | ext_busy;
  assign adc_result = {mdl_ch, 7'h2A};
  always @(posedge clk) begin
    if (!rst_n) begin
      mdl_busy <= 1'b0; adc_done <= 1'b0; mdl_cnt <= 0;
    end else begin
      adc_done <= 1'b0;
      if (mdl_cnt > 0) begin
        mdl_cnt <= mdl_cnt - 1;
        if (mdl_cnt == 1) begin adc_done <= 1'b1; mdl_busy <= 1'b0; end
      end else if (adc_start) begin
        mdl_busy <= 1'b1; mdl_cnt <= adc_lat; mdl_ch <= adc_chan;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid && res_ready && n_wr < 32) begin
        log_addr[n_wr] = res_addr; log_data[n_wr] = res_data; n_wr++;
      end
      if (seq_irq) begin irq_cnt++; n_at_irq = n_wr; end
      if (adc_start) start_cnt++;
    end
  end

  function automatic logic [11:0] exp_data(input int ch);
    return {ch[4:0], 7'h2A};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic clr_log();
    n_wr = 0; irq_cnt = 0; start_cnt = 0; n_at_irq = -1;
  endtask

  task automatic set_slot(input int s, input bit en, input int src, input int ch);
    slot_en[s] = en;
    slot_src[s*4 +: 4] = src[3:0];
    slot_chan[s*5 +: 5] = ch[4:0];
  endtask

  task automatic reload_pulse(input bit clear);
    @(posedge clk); #2 pwm_reload = 1'b1;
    @(posedge clk); #2 pwm_reload = 1'b0;
    if (clear) clr_log();
  endtask

  task automatic drive_code(input int code, input bit v);
    if (code < 2) phase[code] = v;
    else if (code < 8) dt[code-2] = v;
    else net = v;
  endtask

  task automatic pulse_code(input int code);
    @(posedge clk); #2 drive_code(code, 1'b1);
    @(posedge clk); #2 drive_code(code, 1'b0);
  endtask

  task automatic new_period();
    slot_en = '0;
    reload_pulse(1'b1);
  endtask

  task automatic t_reset();
    check(!adc_start && !res_valid && !seq_irq && !overrun, "R1 reset outputs",
          {adc_start, res_valid, seq_irq, overrun}, 0);
  endtask

  task automatic t_single();
    new_period();
    set_slot(0, 1, 0, 3);
    pulse_code(0);
    cyc(25);
    check(n_wr == 1, "R3 one conversion", n_wr, 1);
    check(log_addr[0] == BASE, "R7 address slot0", log_addr[0], BASE);
    check(log_data[0] == exp_data(3), "R7 data", log_data[0], exp_data(3));
    check(irq_cnt == 1, "R9 irq after single", irq_cnt, 1);
    pulse_code(0);
    cyc(25);
    check(n_wr == 1, "R3 repeat event ignored", n_wr, 1);
  endtask

  task automatic t_sources();
    for (int c = 0; c < 9; c++) begin
      new_period();
      set_slot(5, 1, c, c + 1);
      pulse_code(c);
      cyc(25);
      check(n_wr == 1 && log_addr[0] == BASE + 8'd5, "R2 source code map", n_wr, 1);
    end
    new_period();
    set_slot(5, 1, 11, 1);
    @(posedge clk); #2 phase = '1; dt = '1; net = 1'b1;
    @(posedge clk); #2 phase = '0; dt = '0; net = 1'b0;
    cyc(25);
    check(n_wr == 0, "R2 unused code never fires", n_wr, 0);
  endtask

  task automatic t_disabled();
    new_period();
    set_slot(2, 0, 8, 4);
    set_slot(3, 1, 0, 4);
    pulse_code(8);
    cyc(25);
    check(n_wr == 0 && start_cnt == 0, "R4 disabled slot", n_wr, 0);
  endtask

  task automatic t_order();
    new_period();
    set_slot(6, 1, 8, 16);
    set_slot(4, 1, 8, 14);
    set_slot(1, 1, 8, 11);
    set_slot(0, 1, 8, 10);
    pulse_code(8);
    cyc(80);
    check(n_wr == 4, "R5 all queued served", n_wr, 4);
    check(log_addr[0] == BASE + 8'd0 && log_addr[1] == BASE + 8'd1 &&
          log_addr[2] == BASE + 8'd4 && log_addr[3] == BASE + 8'd6,
          "R5 ascending order", log_addr[2], BASE + 8'd4);
    check(log_data[3] == exp_data(16), "R7 data slot6", log_data[3], exp_data(16));
    check(irq_cnt == 1, "R9 single irq per sequence", irq_cnt, 1);
    check(n_at_irq == 4, "R9 irq after last write", n_at_irq, 4);
  endtask

  task automatic t_overrun();
    adc_lat = 8;
    new_period();
    set_slot(0, 1, 8, 2);
    set_slot(1, 1, 8, 3);
    pulse_code(8);
    pulse_code(8);
    cyc(3);
    check(overrun == 1'b1, "R6 overrun set", overrun, 1);
    cyc(50);
    check(n_wr == 2, "R6 lost event no extra write", n_wr, 2);
    check(overrun == 1'b1, "R6 overrun sticky", overrun, 1);
    reload_pulse(1'b1);
    cyc(1);
    check(overrun == 1'b0, "R10 reload clears overrun", overrun, 0);
    adc_lat = 4;
  endtask

  task automatic t_backpressure();
    logic [7:0]  a0;
    logic [11:0] d0;
    new_period();
    res_ready = 1'b0;
    set_slot(0, 1, 8, 5);
    set_slot(1, 1, 8, 6);
    pulse_code(8);
    cyc(20);
    a0 = res_addr; d0 = res_data;
    check(res_valid && a0 == BASE, "R8 word presented", a0, BASE);
    cyc(12);
    check(res_valid && res_addr == a0 && res_data == d0, "R8 word held",
          res_data, d0);
    check(start_cnt == 1, "R8 no start while stalled", start_cnt, 1);
    res_ready = 1'b1;
    cyc(30);
    check(n_wr == 2 && log_data[0] == exp_data(5) && log_data[1] == exp_data(6),
          "R8 both words after release", n_wr, 2);
    check(irq_cnt == 1, "R9 irq after stall", irq_cnt, 1);
  endtask

  task automatic t_reload_same_edge();
    new_period();
    set_slot(0, 1, 8, 1);
    @(posedge clk); #2 net = 1'b1; pwm_reload = 1'b1;
    @(posedge clk); #2 net = 1'b0; pwm_reload = 1'b0;
    cyc(25);
    check(n_wr == 0, "R10 event with reload ignored", n_wr, 0);
  endtask

  task automatic t_reload_midconv();
    adc_lat = 8;
    new_period();
    set_slot(0, 1, 0, 7);
    pulse_code(0);
    cyc(3);
    reload_pulse(1'b0);
    cyc(30);
    check(n_wr == 1, "R11 in-flight result written", n_wr, 1);
    check(irq_cnt == 0, "R11 stale write no irq", irq_cnt, 0);
    pulse_code(0);
    cyc(30);
    check(n_wr == 2 && irq_cnt == 1, "R11 new period completes", irq_cnt, 1);
    adc_lat = 4;
  endtask

  task automatic t_busy();
    new_period();
    ext_busy = 1'b1;
    set_slot(0, 1, 8, 9);
    pulse_code(8);
    cyc(10);
    check(start_cnt == 0, "R12 no start while busy", start_cnt, 0);
    ext_busy = 1'b0;
    cyc(25);
    check(start_cnt == 1 && n_wr == 1, "R12 start after busy clears", start_cnt, 1);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    res_ready = 1'b1;
    cyc(4);
    rst_n = 1'b1;
    #5;
    t_reset();
    t_single();
    t_sources();
    t_disabled();
    t_order();
    t_overrun();
    t_backpressure();
    t_reload_same_edge();
    t_reload_midconv();
    t_busy();
    summary();
  end
endmodule